// File: doc/BRIEF.md
# Piezo Drive Configuration Target on a Two-Wire Serial Bus

This block is the configuration front end of a piezoelectric actuator driver. It listens as a target on an I2C bus. It samples SCL and SDA with the fast system clock, so the slow bus lines pass through a synchronizer and a glitch filter before any edge is decoded. A write transfer names a starting register and then streams data bytes. Each byte lands at the current location, and the location then steps forward by one. The 28 writable settings (control, waveform timing and ramp shaping) are exported as one flat vector to the waveform and sequencing logic. A read transfer returns a single status byte that carries the actuator busy flag.

Register 00h is the motion command: bit 7 selects the direction and bits 6:0 give a move count. When the driver is enabled, each write to it fires a one-cycle drive strobe. The same write adds count times steps-per-count to a pending step total. That total saturates, it is cleared by a change of direction, and the sequencer draws it down one step at a time.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset all 28 registers read 00h, the pending total is 0, SDA is not driven and no strobe is given.
- R2: A first byte of 1110010 followed by a direction bit is acknowledged. Any other target address is not acknowledged, and every later byte is ignored until the next start, with no register changed.
- R3: In a write, the low 5 bits of the second byte set the register pointer. Each following data byte is stored at the pointer, and the pointer then increases by one.
- R4: The pointer steps from 1Fh to 00h. Locations 1Ch to 1Fh store nothing.
- R5: A read returns the byte {busy_i, 7'b0000000}, most significant bit first, and the transfer ends when the controller does not acknowledge.
- R6: A stop (SDA rising while SCL is high) releases SDA and discards an unfinished byte. A start (SDA falling while SCL is high) always begins a new address phase.
- R7: With the enable bit set, a data byte written to 00h gives exactly one drive_strobe_o pulse at that byte's acknowledge. It also adds bits 6:0 times (register 06h + 1) to the pending total.
- R8: The pending total never exceeds 512; a sum above it is held at 512.
- R9: A write to 00h whose bit 7 differs from the stored direction clears the pending total before adding. A direction change with count 0 therefore leaves it at 0.
- R10: While register 01h bit 5 (enable) is 0, the pending total is held at 0. Writes to 00h then store only bit 7, keep bits 6:0 unchanged and give no strobe.
- R11: Each cycle with step_taken_i high lowers a non-zero pending total by one. A total of zero stays at zero.
- R12: The target pulls SDA low during the ninth SCL pulse of an acknowledged byte and releases it after that pulse falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| busy_i | input | 1 | Actuator busy flag for the status read |
| step_taken_i | input | 1 | One pending step consumed by the sequencer |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| drive_strobe_o | output | 1 | One-cycle motion command pulse |
| pending_steps_o | output | 10 | Saturating pending step total |
| regs_o | output | 224 | Register n at bits [8n+7:8n] |

## Verification
The register store is tried with single writes spread over scattered locations, each with a distinct bit pattern. This shows that the pointer lands where it should and that no byte is shifted by one. Bursts that run across 1Fh tell a correct 5-bit wrap apart from an overflow into an unstored location. The motion register is driven with same-direction repeats, direction flips with and without a count, large step values and writes while disabled. These cases separate accumulation, clearing, saturation and suppression from one another. Foreign addresses and a stop in mid-byte show that traffic not meant for the target leaves the state untouched.

// File: rtl/pzcfg_pkg.sv
package pzcfg_pkg;
  localparam int unsigned REG_COUNT = 28;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned PTR_W     = 5;
  localparam int unsigned PEND_MAX  = 512;
  localparam int unsigned PEND_W    = $clog2(PEND_MAX + 1);
  localparam logic [6:0]  DEV_ADDR  = 7'b1110010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_DEV, PH_REG, PH_DATA
  } byte_phase_t;

  // steps requested by one command byte: count times (code + 1)
  function automatic logic [16:0] step_request(input logic [6:0] count,
                                               input logic [7:0] step_code);
    return 17'(count) * (17'(step_code) + 17'd1);
  endfunction

  // saturating accumulate of the pending total
  function automatic logic [PEND_W-1:0] pend_add(input logic [PEND_W-1:0] base,
                                                 input logic [16:0] extra);
    logic [17:0] total;
    total = 18'(base) + 18'(extra);
    if (total > 18'(PEND_MAX)) return PEND_W'(PEND_MAX);
    return total[PEND_W-1:0];
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(STABLE + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      line_o   <= 1'b1;
      hold_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        hold_cnt <= '0;
      end else if (hold_cnt == CW'(STABLE - 1)) begin
        line_o   <= sync_q[1];
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import pzcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic [7:0]       status_byte,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [7:0]       wr_data,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             nomatch_evt
);
  bus_state_t  state;
  byte_phase_t phase;
  logic             scl_q, sda_q;
  logic [7:0]       shreg, txsh;
  logic [3:0]       bitcnt;
  logic             rd_dir, nack_q;
  logic [PTR_W-1:0] ptr;
  logic             scl_rise, scl_fall;

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_evt = scl & scl_q & sda_q & ~sda;
  assign stop_evt  = scl & scl_q & ~sda_q & sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      phase       <= PH_DEV;
      shreg       <= '0;
      txsh        <= '0;
      bitcnt      <= '0;
      rd_dir      <= 1'b0;
      nack_q      <= 1'b0;
      ptr         <= '0;
      wr_en       <= 1'b0;
      wr_ptr      <= '0;
      wr_data     <= '0;
      nomatch_evt <= 1'b0;
    end else begin
      wr_en       <= 1'b0;
      nomatch_evt <= 1'b0;
      if (start_evt) begin
        state  <= ST_RX;
        phase  <= PH_DEV;
        bitcnt <= '0;
      end else if (stop_evt) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              unique case (phase)
                PH_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    state  <= ST_ACK;
                    rd_dir <= shreg[0];
                  end else begin
                    state       <= ST_IDLE;
                    nomatch_evt <= 1'b1;
                  end
                end
                PH_REG: begin
                  ptr   <= shreg[PTR_W-1:0];
                  state <= ST_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_ptr  <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                  state   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (phase == PH_DEV && rd_dir) begin
                state <= ST_TX;
                txsh  <= status_byte;
              end else begin
                state <= ST_RX;
                phase <= (phase == PH_DEV) ? PH_REG : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                state  <= ST_TXACK;
                bitcnt <= '0;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) nack_q <= sda;
            else if (scl_fall) begin
              if (nack_q) state <= ST_IDLE;
              else begin
                state <= ST_TX;
                txsh  <= status_byte;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_ACK:  sda_oe = 1'b1;
      ST_TX:   sda_oe = ~txsh[7];
      default: sda_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import pzcfg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              wr_ptr,
  input  logic [7:0]                    wr_data,
  input  logic                          step_taken,
  output logic [REG_COUNT*DATA_W-1:0]   regs_flat,
  output logic                          drive_strobe,
  output logic [PEND_W-1:0]             pending,
  output logic                          enable
);
  logic [DATA_W-1:0] cfg_q [REG_COUNT];
  logic              cmd_hit, dir_flip;

  assign enable   = cfg_q[1][5];
  assign cmd_hit  = wr_en && (wr_ptr == '0) && enable;
  assign dir_flip = wr_data[7] != cfg_q[0][7];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (wr_en && wr_ptr == PTR_W'(g)) begin
        if (g == 0) cfg_q[g] <= enable ? wr_data : {wr_data[7], cfg_q[g][6:0]};
        else        cfg_q[g] <= wr_data;
      end
    end
    assign regs_flat[g*DATA_W +: DATA_W] = cfg_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_strobe <= 1'b0;
      pending      <= '0;
    end else begin
      drive_strobe <= cmd_hit;
      if (!enable)
        pending <= '0;
      else if (cmd_hit)
        pending <= pend_add(dir_flip ? '0 : pending,
                            step_request(wr_data[6:0], cfg_q[6]));
      else if (step_taken && pending != '0)
        pending <= pending - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import pzcfg_pkg::*;
#(
  parameter int unsigned FILTER_LEN = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  input  logic                        busy_i,
  input  logic                        step_taken_i,
  output logic                        sda_oe_o,
  output logic                        drive_strobe_o,
  output logic [PEND_W-1:0]           pending_steps_o,
  output logic [REG_COUNT*DATA_W-1:0] regs_o
);
  logic [1:0]       raw_lines, clean_lines;
  logic             start_evt, stop_evt, nomatch_evt;
  logic             wr_en, cfg_enable;
  logic [PTR_W-1:0] wr_ptr;
  logic [7:0]       wr_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar k = 0; k < 2; k++) begin : g_filt
    i2c_line_filter #(.STABLE(FILTER_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[k]),
      .line_o (clean_lines[k])
    );
  end

  i2c_target_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl         (clean_lines[0]),
    .sda         (clean_lines[1]),
    .status_byte ({busy_i, 7'b0}),
    .sda_oe      (sda_oe_o),
    .wr_en       (wr_en),
    .wr_ptr      (wr_ptr),
    .wr_data     (wr_data),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .nomatch_evt (nomatch_evt)
  );

  cfg_store u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_ptr       (wr_ptr),
    .wr_data      (wr_data),
    .step_taken   (step_taken_i),
    .regs_flat    (regs_o),
    .drive_strobe (drive_strobe_o),
    .pending      (pending_steps_o),
    .enable       (cfg_enable)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
  import pzcfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe_o,
  input logic              drive_strobe_o,
  input logic [PEND_W-1:0] pending_steps_o,
  input logic              cfg_enable,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              nomatch_evt,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_ptr
);
  assert_pending_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pending_steps_o <= PEND_W'(PEND_MAX));

  assert_disabled_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> pending_steps_o == '0);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_strobe_o |=> !drive_strobe_o);

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_strobe_o |-> $past(wr_en && wr_ptr == '0));

  assert_nomatch_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nomatch_evt |=> !sda_oe_o);

  assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);

  assert_start_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe_o);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sda_oe_o        (sda_oe_o),
  .drive_strobe_o  (drive_strobe_o),
  .pending_steps_o (pending_steps_o),
  .cfg_enable      (cfg_enable),
  .start_evt       (start_evt),
  .stop_evt        (stop_evt),
  .nomatch_evt     (nomatch_evt),
  .wr_en           (wr_en),
  .wr_ptr          (wr_ptr)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 25;
  localparam int NVEC = 8;
  // {register, data}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0281, 16'h0315, 16'h0536, 16'h070A,
    16'h0C3F, 16'h12A5, 16'h1BC3, 16'h0418
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy_i = 1'b0, step_taken_i = 1'b0;
  logic sda_oe_o, drive_strobe_o;
  logic [9:0] pending_steps_o;
  logic [223:0] regs_o;
  logic sda_bus;
  int checks = 0, errors = 0, strobes = 0;
  bit done = 0;
  bit ack_seen, rel_seen;

  assign sda_bus = sda_m & ~sda_oe_o;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (drive_strobe_o) strobes++;

  cfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .busy_i(busy_i), .step_taken_i(step_taken_i), .sda_oe_o(sda_oe_o),
    .drive_strobe_o(drive_strobe_o), .pending_steps_o(pending_steps_o),
    .regs_o(regs_o)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rg(input int i);
    return int'(regs_o[i*8 +: 8]);
  endfunction

  task automatic bstart;
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bstop;
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    ack_seen = ~sda_bus;
    wq(Q); scl_m = 0; wq(Q);
    rel_seen = sda_bus;
  endtask

  task automatic recv(output logic [7:0] b, input bit nack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 0; wq(Q);
    end
    sda_m = nack; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q); sda_m = 1;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    bstart; send(8'hE4); send(a); send(d); bstop;
  endtask

  task automatic rd_status(output logic [7:0] b);
    bstart; send(8'hE5); recv(b, 1'b1); bstop;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    int s0;
    wq(5);
    // R1 reset state
    chk("R1 regs", int'(regs_o == '0), 1);
    chk("R1 pending", int'(pending_steps_o), 0);
    chk("R1 sda", int'(sda_oe_o), 0);
    rst_n = 1; wq(10);
    chk("R1 strobes", strobes, 0);

    // R3 table of single writes
    for (int v = 0; v < NVEC; v++) begin
      wr1(VEC[v][15:8], VEC[v][7:0]);
      chk("R3 table", rg(int'(VEC[v][15:8])), int'(VEC[v][7:0]));
    end

    // R2 / R12 matched address ack and release
    bstart; send(8'hE4);
    chk("R2 match ack", int'(ack_seen), 1);
    chk("R12 released after ninth", int'(rel_seen), 1);
    // R3 burst with increment
    send(8'h13); send(8'h11); send(8'h22); send(8'h33); bstop;
    chk("R3 burst 13", rg(8'h13), 8'h11);
    chk("R3 burst 14", rg(8'h14), 8'h22);
    chk("R3 burst 15", rg(8'h15), 8'h33);

    // R2 foreign address ignored until next start
    bstart; send(8'hE6);
    chk("R2 nomatch nack", int'(ack_seen), 0);
    send(8'h02); send(8'h55); bstop;
    chk("R2 ignored", rg(2), 8'h81);

    // R4 wrap (disabled: R10 direction stored, count dropped)
    bstart; send(8'hE4); send(8'h1E); send(8'h44); send(8'h55); send(8'h85); bstop;
    chk("R4 wrap to 00", rg(0), 8'h80);
    chk("R4 1B untouched", rg(8'h1B), 8'hC3);
    chk("R10 no strobe", strobes, 0);
    chk("R10 pending", int'(pending_steps_o), 0);

    // R5 status read
    busy_i = 1; rd_status(rb);
    chk("R5 busy", int'(rb), 8'h80);
    busy_i = 0; rd_status(rb);
    chk("R5 idle", int'(rb), 8'h00);

    // R7 accumulate
    wr1(8'h01, 8'h20); wr1(8'h06, 8'h02);
    s0 = strobes;
    wr1(8'h00, 8'h85);
    chk("R7 first", int'(pending_steps_o), 15);
    chk("R7 strobe", strobes - s0, 1);
    wr1(8'h00, 8'h83);
    chk("R7 add", int'(pending_steps_o), 24);

    // R11 consume
    step_taken_i = 1; wq(4); step_taken_i = 0; wq(2);
    chk("R11 dec", int'(pending_steps_o), 20);

    // R9 direction change
    wr1(8'h00, 8'h02);
    chk("R9 flip", int'(pending_steps_o), 6);
    wr1(8'h00, 8'h80);
    chk("R9 stop", int'(pending_steps_o), 0);

    // R8 saturation
    wr1(8'h06, 8'hFF);
    wr1(8'h00, 8'h03);
    chk("R8 sat", int'(pending_steps_o), 512);
    wr1(8'h00, 8'h01);
    chk("R8 hold", int'(pending_steps_o), 512);

    // R11 floor at zero
    wr1(8'h00, 8'h80);
    step_taken_i = 1; wq(3); step_taken_i = 0; wq(2);
    chk("R11 floor", int'(pending_steps_o), 0);

    // R10 disable clears and blocks
    wr1(8'h00, 8'h01);
    chk("R10 pre", int'(pending_steps_o), 256);
    wr1(8'h01, 8'h00);
    chk("R10 cleared", int'(pending_steps_o), 0);
    s0 = strobes;
    wr1(8'h00, 8'h05);
    chk("R10 count kept", rg(0), 8'h01);
    chk("R10 strobe", strobes - s0, 0);

    // R6 stop in mid-byte
    bstart; send(8'hE4); send(8'h02);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
    bstop;
    chk("R6 partial dropped", rg(2), 8'h81);
    chk("R6 released", int'(sda_oe_o), 0);
    wr1(8'h02, 8'h7E);
    chk("R6 next start", rg(2), 8'h7E);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule